// File: doc/BRIEF.md
# Digital Fine Gain Control Loop

This block sits on a complex baseband sample stream and scales the I and Q components by a digital gain. The gain is chosen so that the average power of the scaled stream settles on a programmable level, usually placed 6 to 12 dB below digital full-scale so that signal peaks still fit. The loop is closed around its own output. Power is averaged over a block of samples and converted to a logarithmic value. The difference from the target is filtered by an integrator, or by a proportional-plus-integral filter. The result is a gain in dB, held within a ±10 dB fine range, and a table turns it into a linear multiplier.

The gain changes only at block boundaries. Between updates every sample sees the same multiplier. A freeze input holds the gain at its current value while the power detector keeps running. Target, filter mode, filter shifts and gain limit are static configuration inputs. The window length, sample width and multiplier precision are parameters.

Top module: `agc_fine`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `out_vld`=0, `out_i`=`out_q`=0 and `gain_db`=0. The multiplier in effect is unity (4096).
- R2: A sample with `in_vld`=1 at edge k appears at edge k with `out_vld`=1. Each component equals floor((x·G + 2048)/4096), saturated to [-2048, 2047]. G is the multiplier in effect before that edge. When `in_vld`=0 the outputs keep their last values and `out_vld`=0.
- R3: Power is measured on the output samples over windows of 16 consecutive valid samples. The value is floor(Σ(y_i²+y_q²)/16).
- R4: A power p>0 with leading one at bit m gives L = 16·m + the four bits directly below the leading one, taken as an integer, with zeros filled in below bit 0. The measured level is M = L + floor(L/2), in units of 1/8 dB. Zero power gives M=0.
- R5: In integrator mode (`cfg_pi`=0), each window result sets the integrator to clamp(I + (e >>> `cfg_ki_sh`)), where e = `cfg_tgt` − M. The shift is arithmetic, rounding toward minus infinity. `gain_db` equals the integrator.
- R6: In proportional-plus-integral mode (`cfg_pi`=1), the integrator updates as in R5. `gain_db` becomes clamp(I_new + (e >>> `cfg_kp_sh`)).
- R7: Every clamp uses ±min(`cfg_lim`, 80), so `gain_db` never leaves ±10 dB. The integrator saturates at the same limit.
- R8: When the last sample of a window arrives at edge t, `gain_db` changes at edge t+1. The new multiplier G = round(4096·10^(gain_db/160)) is in effect from edge t+3 on. The gain changes at no other time.
- R9: When `freeze` is high at the edge where a window result would be applied, neither `gain_db` nor the integrator changes.
- R10: With a constant-power input that stays in range, the output power settles within 1 dB of the level whose M equals `cfg_tgt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | Hold gain and integrator |
| cfg_pi | input | 1 | 0 = integrator only, 1 = proportional plus integral |
| cfg_tgt | input | 10 | Target level, 1/8 dB units |
| cfg_ki_sh | input | 3 | Integral path right shift |
| cfg_kp_sh | input | 3 | Proportional path right shift |
| cfg_lim | input | 8 | Gain limit magnitude, 1/8 dB, capped at 80 |
| in_vld | input | 1 | Input sample valid |
| in_i | input | 12 | Input I, signed |
| in_q | input | 12 | Input Q, signed |
| out_vld | output | 1 | Output sample valid |
| out_i | output | 12 | Scaled I, signed |
| out_q | output | 12 | Scaled Q, signed |
| gain_db | output | 8 | Current gain, signed, 1/8 dB |

## Verification
The bench drives inputs far too small for the fine range, then full-scale inputs while the gain sits at +10 dB. This exercises the clamp and the output saturation together. A missing clamp would walk the gain past ±80 units. A wrapping multiplier would flip the sign of large samples instead of pinning them. Gaps in `in_vld` and the three-edge latency from window end to new multiplier are checked every cycle. A detector that counted idle cycles, or a gain that took effect one edge early or late, therefore shows up as a sample mismatch. Zero input and a limit above 80 test the log of zero and the cap on the limit. A freeze held across an amplitude change shows whether a window result leaks through.

// File: rtl/agc_pkg.sv
package agc_pkg;

  typedef enum logic {
    LF_INT = 1'b0,
    LF_PI  = 1'b1
  } lf_mode_e;

  function automatic int clamp_i(input int v, input int lo, input int hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/agc_scaler.sv
module agc_scaler #(
  parameter int DW = 12,
  parameter int GF = 12,
  parameter int GW = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic        [GW-1:0] lin,
  output logic signed [DW-1:0] y_i,
  output logic signed [DW-1:0] y_q,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam int PRW = DW + GW + 1;
  localparam logic signed [PRW-1:0] HALF = PRW'(1 << (GF - 1));
  localparam logic signed [PRW-1:0] HI   = PRW'((1 << (DW - 1)) - 1);
  localparam logic signed [PRW-1:0] LO   = -HI - PRW'(1);
  localparam logic        [GW-1:0]  ONE  = GW'(1 << GF);

  logic signed [GW:0]    lin_s;
  logic signed [PRW-1:0] p_i, p_q;

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [PRW-1:0] p);
    logic signed [PRW-1:0] r;
    r = (p + HALF) >>> GF;
    if (r > HI) r = HI;
    else if (r < LO) r = LO;
    return DW'(r);
  endfunction

  assign lin_s = {1'b0, lin};
  assign p_i   = PRW'(in_i) * PRW'(lin_s);
  assign p_q   = PRW'(in_q) * PRW'(lin_s);
  assign y_i   = rnd_sat(p_i);
  assign y_q   = rnd_sat(p_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_i   <= '0;
      out_q   <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_i <= y_i;
        out_q <= y_q;
      end
    end
  end

  // R2: unity multiplier passes samples through unchanged
  assert_unity_passthru_R2: assert property (@(posedge clk) disable iff (rst)
    (in_vld && lin == ONE) |=> (out_vld && out_i == $past(in_i) && out_q == $past(in_q)));

endmodule

// File: rtl/agc_pwr_det.sv
module agc_pwr_det #(
  parameter int DW = 12,
  parameter int WL = 4,
  parameter int PW = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [DW-1:0] y_q,
  output logic                 pwr_vld,
  output logic        [PW-1:0] pwr
);
  localparam int AW = PW + WL;

  logic        [WL-1:0] cnt;
  logic        [AW-1:0] acc, acc_nx;
  logic signed [PW-1:0] si, sq;
  logic        [PW-1:0] s;

  assign si     = PW'(y_i) * PW'(y_i);
  assign sq     = PW'(y_q) * PW'(y_q);
  assign s      = unsigned'(si) + unsigned'(sq);
  assign acc_nx = acc + AW'(s);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      acc     <= '0;
      pwr     <= '0;
      pwr_vld <= 1'b0;
    end else begin
      pwr_vld <= 1'b0;
      if (smp_vld) begin
        cnt <= cnt + WL'(1);
        if (&cnt) begin
          pwr     <= PW'(acc_nx >> WL);
          pwr_vld <= 1'b1;
          acc     <= '0;
        end else begin
          acc <= acc_nx;
        end
      end
    end
  end

  // R3: a window result follows only the last sample of a window
  assert_window_close_R3: assert property (@(posedge clk) disable iff (rst)
    pwr_vld |-> $past(smp_vld && (&cnt)));

  // R3: counter restarts after every window result
  assert_count_restart_R3: assert property (@(posedge clk) disable iff (rst)
    pwr_vld |-> (cnt == '0));

endmodule

// File: rtl/agc_log_db.sv
module agc_log_db #(
  parameter int PW  = 24,
  parameter int LW  = 5,
  parameter int DBW = 10
) (
  input  logic [PW-1:0]  pwr,
  output logic [DBW-1:0] db
);
  // Four fraction bits of log2 are tied to the 1/8 dB unit: 8*3.0103/16 ~ 1.5
  localparam int FR = 4;

  logic [LW-1:0]    msb;
  logic [FR-1:0]    mant;
  logic [LW+FR-1:0] lg;

  always_comb begin
    msb = '0;
    for (int k = 0; k < PW; k++) begin
      if (pwr[k]) msb = LW'(k);
    end
    if (int'(msb) >= FR) mant = FR'(pwr >> (int'(msb) - FR));
    else                 mant = FR'(pwr << (FR - int'(msb)));
    lg = {msb, mant};
    db = DBW'(lg) + DBW'(lg >> 1);
  end

endmodule

// File: rtl/agc_loop_filt.sv
module agc_loop_filt
  import agc_pkg::*;
#(
  parameter int DBW  = 10,
  parameter int GDW  = 8,
  parameter int GLIM = 80
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  upd,
  input  logic                  freeze,
  input  logic                  mode_pi,
  input  logic        [DBW-1:0] tgt,
  input  logic        [DBW-1:0] meas,
  input  logic        [2:0]     ki_sh,
  input  logic        [2:0]     kp_sh,
  input  logic        [GDW-1:0] lim,
  output logic signed [GDW-1:0] gain_db
);
  lf_mode_e mode;
  logic signed [GDW-1:0] integ;
  int lim_i, err, i_nx, g_nx;

  assign mode = mode_pi ? LF_PI : LF_INT;

  always_comb begin
    lim_i = (int'(lim) > GLIM) ? GLIM : int'(lim);
    err   = int'(tgt) - int'(meas);
    i_nx  = clamp_i(int'(integ) + (err >>> ki_sh), -lim_i, lim_i);
    if (mode == LF_PI) g_nx = clamp_i(i_nx + (err >>> kp_sh), -lim_i, lim_i);
    else               g_nx = i_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ   <= '0;
      gain_db <= '0;
    end else if (upd && !freeze) begin
      integ   <= GDW'(i_nx);
      gain_db <= GDW'(g_nx);
    end
  end

  assert_gain_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    (int'(gain_db) <= lim_i) && (int'(gain_db) >= -lim_i));

  assert_integ_in_range_R7: assert property (@(posedge clk) disable iff (rst)
    (int'(integ) <= lim_i) && (int'(integ) >= -lim_i));

  assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(gain_db) && $stable(integ));

  assert_step_on_window_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(gain_db) |-> $past(upd));

endmodule

// File: rtl/agc_gain_rom.sv
module agc_gain_rom #(
  parameter int GDW  = 8,
  parameter int GLIM = 80,
  parameter int GF   = 12,
  parameter int GW   = 14,
  parameter int DBU  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic signed [GDW-1:0] gain_db,
  output logic        [GW-1:0]  lin
);
  localparam int DEPTH = 2 * GLIM + 1;
  localparam int AWR   = $clog2(DEPTH);
  localparam int ONE_I = 1 << GF;

  logic [GW-1:0]  rom [DEPTH];
  logic [AWR-1:0] addr;
  int ix;

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      rom[k] = GW'($rtoi(real'(ONE_I) *
               (10.0 ** (real'(k - GLIM) / (20.0 * real'(DBU)))) + 0.5));
    end
  end

  always_comb begin
    ix   = int'(gain_db) + GLIM;
    if (ix < 0) ix = 0;
    if (ix > DEPTH - 1) ix = DEPTH - 1;
    addr = AWR'(ix);
  end

  always_ff @(posedge clk) begin
    if (rst) lin <= GW'(ONE_I);
    else     lin <= rom[addr];
  end

  // R8: the multiplier follows the gain word one edge later
  assert_lin_follows_R8: assert property (@(posedge clk) disable iff (rst)
    $stable(gain_db) && $past($stable(gain_db)) |-> $stable(lin));

endmodule

// File: rtl/agc_fine.sv
module agc_fine #(
  parameter int DW   = 12,
  parameter int WL   = 4,
  parameter int GF   = 12,
  parameter int GLIM = 80,
  parameter int DBU  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                freeze,
  input  logic                cfg_pi,
  input  logic [9:0]          cfg_tgt,
  input  logic [2:0]          cfg_ki_sh,
  input  logic [2:0]          cfg_kp_sh,
  input  logic [7:0]          cfg_lim,
  input  logic                in_vld,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                out_vld,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  output logic signed [7:0]   gain_db
);
  localparam int PW  = 2 * DW;
  localparam int LW  = $clog2(PW);
  localparam int DBW = LW + 4 + 1;
  localparam int GW  = GF + 2;
  localparam int GDW = $clog2(GLIM + 1) + 1;

  logic        [GW-1:0]  lin;
  logic signed [DW-1:0]  y_i, y_q;
  logic                  pwr_vld;
  logic        [PW-1:0]  pwr;
  logic        [DBW-1:0] meas;
  logic signed [GDW-1:0] g;

  agc_scaler #(.DW(DW), .GF(GF), .GW(GW)) u_scl (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_i(in_i), .in_q(in_q), .lin(lin),
    .y_i(y_i), .y_q(y_q), .out_vld(out_vld), .out_i(out_i), .out_q(out_q));

  agc_pwr_det #(.DW(DW), .WL(WL), .PW(PW)) u_det (
    .clk(clk), .rst(rst), .smp_vld(in_vld), .y_i(y_i), .y_q(y_q),
    .pwr_vld(pwr_vld), .pwr(pwr));

  agc_log_db #(.PW(PW), .LW(LW), .DBW(DBW)) u_log (
    .pwr(pwr), .db(meas));

  agc_loop_filt #(.DBW(DBW), .GDW(GDW), .GLIM(GLIM)) u_lf (
    .clk(clk), .rst(rst), .upd(pwr_vld), .freeze(freeze), .mode_pi(cfg_pi),
    .tgt(DBW'(cfg_tgt)), .meas(meas), .ki_sh(cfg_ki_sh), .kp_sh(cfg_kp_sh),
    .lim(GDW'(cfg_lim > 8'(GLIM) ? 8'(GLIM) : cfg_lim)), .gain_db(g));

  agc_gain_rom #(.GDW(GDW), .GLIM(GLIM), .GF(GF), .GW(GW), .DBU(DBU)) u_rom (
    .clk(clk), .rst(rst), .gain_db(g), .lin(lin));

  assign gain_db = 8'(g);

endmodule

// File: tb/sim_agc_fine.sv
module sim_agc_fine;
  localparam int DW = 12, WL = 4, GF = 12, N = 1 << WL;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, freeze = 1'b0, cfg_pi = 1'b0, in_vld = 1'b0;
  logic [9:0] cfg_tgt = 10'd456;
  logic [2:0] cfg_ki_sh = 3'd2, cfg_kp_sh = 3'd1;
  logic [7:0] cfg_lim = 8'd80;
  logic signed [DW-1:0] in_i = '0, in_q = '0;
  logic out_vld;
  logic signed [DW-1:0] out_i, out_q;
  logic signed [7:0] gain_db;

  agc_fine u0 (.clk(clk), .rst(rst), .freeze(freeze), .cfg_pi(cfg_pi), .cfg_tgt(cfg_tgt),
    .cfg_ki_sh(cfg_ki_sh), .cfg_kp_sh(cfg_kp_sh), .cfg_lim(cfg_lim), .in_vld(in_vld),
    .in_i(in_i), .in_q(in_q), .out_vld(out_vld), .out_i(out_i), .out_q(out_q),
    .gain_db(gain_db));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string gtag = "R1";

  // reference model state
  int m_vld, m_oi, m_oq, m_cnt, m_pv, m_g, m_int, m_lin;
  longint m_acc, m_pwr;
  longint rb [N];
  int rb_n = 0;

  function automatic int tab(input int g);
    return $rtoi(4096.0 * (10.0 ** (real'(g) / 160.0)) + 0.5);
  endfunction

  function automatic int scale(input int x, input int g);
    longint p;
    p = (longint'(x) * g + (64'sd1 <<< (GF - 1))) >>> GF;
    if (p > 2047) p = 2047;
    if (p < -2048) p = -2048;
    return int'(p);
  endfunction

  function automatic int db_of(input longint p);
    int m, mant, l;
    if (p == 0) return 0;
    m = 0;
    for (int k = 0; k < 48; k++) if ((p >> k) & 1) m = k;
    if (m >= 4) mant = int'((p >> (m - 4)) & 15);
    else        mant = int'((p << (4 - m)) & 15);
    l = 16 * m + mant;
    return l + l / 2;
  endfunction

  function automatic int clampv(input int v, input int lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  task automatic model_step();
    int ng, ni, nlin, lim, e, yi, yq, npv;
    longint s;
    if (rst) begin
      m_vld = 0; m_oi = 0; m_oq = 0; m_acc = 0; m_cnt = 0; m_pv = 0;
      m_pwr = 0; m_g = 0; m_int = 0; m_lin = tab(0);
      return;
    end
    ng = m_g; ni = m_int;
    lim = (int'(cfg_lim) > 80) ? 80 : int'(cfg_lim);
    if (m_pv != 0 && !freeze) begin
      e  = int'(cfg_tgt) - db_of(m_pwr);
      ni = clampv(m_int + (e >>> cfg_ki_sh), lim);
      ng = cfg_pi ? clampv(ni + (e >>> cfg_kp_sh), lim) : ni;
    end
    nlin = tab(m_g);
    npv = 0;
    if (in_vld) begin
      yi = scale(int'(in_i), m_lin);
      yq = scale(int'(in_q), m_lin);
      m_oi = yi; m_oq = yq;
      s = longint'(yi) * yi + longint'(yq) * yq;
      if (m_cnt == N - 1) begin
        m_pwr = (m_acc + s) >> WL; npv = 1; m_acc = 0; m_cnt = 0;
      end else begin
        m_acc += s; m_cnt++;
      end
    end
    m_vld = int'(in_vld); m_pv = npv; m_g = ng; m_int = ni; m_lin = nlin;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk("R2 out_vld", int'(out_vld), m_vld);
    if (m_vld != 0) begin
      chk("R2 out_i", int'(out_i), m_oi);
      chk("R2 out_q", int'(out_q), m_oq);
      rb[rb_n % N] = longint'(out_i) * out_i + longint'(out_q) * out_q;
      rb_n++;
    end
    // gain word depends on the R3 detector, R4 log, R8 timing and the tagged filter rule
    chk(gtag, int'(gain_db), m_g);
  endtask

  task automatic step(input bit v, input int si, input int sq);
    @(negedge clk);
    in_vld = v; in_i = DW'(si); in_q = DW'(sq);
    @(posedge clk);
    model_step();
    #1;
    compare();
  endtask

  task automatic run(input int cycles, input int amp);
    for (int c = 0; c < cycles; c++) begin
      int a, b;
      a = ($urandom % 2) ? amp : -amp;
      b = ($urandom % 2) ? amp / 2 : -(amp / 2);
      step(($urandom % 4) != 0, a, b);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    gtag = "R1";
    step(0, 0, 0);
    step(0, 0, 0);
    rst = 1'b0;
  endtask

  task automatic settle_check(input string tag);
    real pm, pt;
    pm = 0.0;
    for (int k = 0; k < N; k++) pm += real'(rb[k]);
    pm = pm / N;
    pt = 2.0 ** ((real'(cfg_tgt) / 1.5) / 16.0);
    n_chk++;
    if ((10.0 * $log10(pm + 1.0) - 10.0 * $log10(pt)) > 1.0 ||
        (10.0 * $log10(pt) - 10.0 * $log10(pm + 1.0)) > 1.0) begin
      n_fail++;
      $display("FAIL %s settled power: actual %0f expected %0f", tag, pm, pt);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    chk("R1 gain", int'(gain_db), 0);
    chk("R1 vld", int'(out_vld), 0);
    chk("R1 out_i", int'(out_i), 0);

    // R9: frozen unity gain, samples pass through (R2)
    freeze = 1'b1; gtag = "R9 frozen";
    run(120, 900);
    chk("R9 gain held at 0", int'(gain_db), 0);
    freeze = 1'b0;

    // R5: integrator convergence, R10 settling
    gtag = "R5 integ";
    run(900, 400);
    settle_check("R10 integ");

    // R7: tiny input drives gain to +limit, then large input saturates output (R2)
    cfg_ki_sh = 3'd0; gtag = "R7 upper";
    run(200, 20);
    chk("R7 upper clamp", int'(gain_db), 80);
    run(40, 2000);

    // R7: high input with low target drives gain to -limit
    cfg_tgt = 10'd300; gtag = "R7 lower";
    run(300, 2000);
    chk("R7 lower clamp", int'(gain_db), -80);

    // R6: proportional plus integral mode
    cfg_tgt = 10'd456; cfg_pi = 1'b1; cfg_ki_sh = 3'd3; cfg_kp_sh = 3'd1;
    do_reset(); gtag = "R6 pi";
    run(900, 1500);
    settle_check("R10 pi");

    // R9: freeze across an amplitude change
    freeze = 1'b1; gtag = "R9 freeze";
    begin
      int g0;
      g0 = int'(gain_db);
      run(200, 300);
      chk("R9 gain held", int'(gain_db), g0);
    end
    freeze = 1'b0; gtag = "R6 resume";
    run(200, 300);

    // R7: smaller limit
    cfg_pi = 1'b0; cfg_ki_sh = 3'd1; cfg_lim = 8'd24;
    do_reset(); gtag = "R7 lim24";
    run(200, 100);
    chk("R7 lim 24", int'(gain_db), 24);

    // R4 zero power and R7 limit above 80 capped
    cfg_lim = 8'd100;
    do_reset(); gtag = "R4 zero";
    run(300, 0);
    chk("R7 cap 80", int'(gain_db), 80);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule